// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block keeps the contents of an asynchronous DRAM alive by issuing one refresh cycle per fixed interval. A free-running interval timer marks each refresh slot. A small backlog counter remembers slots that have not yet been served. When a slot is owed and the sequencer is idle, it raises a request to the normal access path. Once it is granted, it drives the row and column strobes through a complete refresh cycle and then pulses a done signal.

Two refresh styles are supported, chosen per cycle by a mode input. In row-address refresh, the block presents a row number from its own row counter and strobes only the row strobe. It then advances the counter. In column-before-row refresh, the column strobe falls one clock before the row strobe and no address is driven. The device steps its own internal row pointer, and the block's row counter is left alone. A width input selects between a device with 2^(ROW_BITS-1) rows and one with 2^ROW_BITS rows. With the default of 9 this covers 256-row and 512-row parts. With the default 50 MHz clock, the 780-cycle interval gives 15.6 us per row. That sweeps 256 rows inside 4 ms and 512 rows inside 8 ms.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is active, ras_n and cas_n are high, ref_req and ref_done are low, addr_en is low and ref_addr is zero.
- R2: The interval timer runs freely from reset release and reloads on every expiry, independent of cycle completion. The first ref_req appears exactly INTERVAL clocks after reset is released.
- R3: A row-address cycle has three phases. First, addr_en is high for exactly one clock while ras_n is still high. Next, ras_n is low for RAS_LOW clocks with ref_addr equal to the current row. cas_n stays high throughout.
- R4: After ras_n returns high, it stays high for PRECHARGE clocks. ref_done then pulses high for one clock, with both strobes high.
- R5: A column-before-row cycle proceeds in order: cas_n falls one clock before ras_n, both stay low for RAS_LOW clocks, then cas_n rises one clock before ras_n. Each strobe is low for RAS_LOW+1 clocks, and addr_en stays low with ref_addr at zero throughout.
- R6: The row counter starts at 0 after reset and advances by one after each completed row-address cycle. With rows_wide=0 it wraps from 255 to 0, and ref_addr bit 8 is always 0. With rows_wide=1 it wraps from 511 to 0.
- R7: A column-before-row cycle leaves the row counter unchanged, so the next row-address cycle uses the same row as before it.
- R8: The backlog of owed slots saturates at 2. After three or more expiries without a grant, exactly two refresh cycles run back to back under a held grant, and ref_req then drops until the next expiry.
- R9: ref_req is high only while a slot is owed and the sequencer is idle. It falls in the clock after a grant is taken, and no strobe moves before a grant.
- R10: ref_gnt has no effect while ref_req is low: ras_n and cas_n stay high and ref_done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cbr | input | 1 | 1 selects column-before-row refresh for the next cycle, 0 selects row-address refresh |
| rows_wide | input | 1 | 1 selects 2^ROW_BITS rows, 0 selects 2^(ROW_BITS-1) rows |
| ref_gnt | input | 1 | Grant from the access path, taken while ref_req is high |
| ref_req | output | 1 | Refresh slot owed and sequencer idle |
| ref_done | output | 1 | One-clock pulse at the end of a refresh cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_en | output | 1 | Row address valid on ref_addr |
| ref_addr | output | ROW_BITS | Row address, zero when addr_en is low |

## Verification
The bench builds the block with INTERVAL=40, RAS_LOW=3 and PRECHARGE=2, keeping ROW_BITS at 9. The short interval makes complete sweeps of both 256 and 512 rows, including the wrap back to zero, affordable in a single run. It also lets three missed slots pile up within about a hundred clocks, which exposes the backlog saturation. The short strobe widths keep every phase of both refresh styles countable clock by clock.

// File: rtl/drfsh_pkg.sv
package drfsh_pkg;
  localparam int PEND_MAX = 2;
  localparam int PEND_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CASPRE,
    ST_STROBE,
    ST_CASREL,
    ST_PRECH,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/drfsh_timer.sv
module drfsh_timer
  import drfsh_pkg::*;
#(
  parameter int INTERVAL = 780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  output logic              tick,
  output logic [PEND_W-1:0] pending,
  output logic              owed
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [PEND_W-1:0] pend_next(input logic [PEND_W-1:0] p,
                                                  input logic add, input logic sub);
    case ({add, sub})
      2'b10:   return (p == PEND_W'(PEND_MAX)) ? p : p + 1'b1;
      2'b01:   return p - 1'b1;
      default: return p;
    endcase
  endfunction

  assign tick = (cnt_q == LAST);
  assign owed = (pending != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= '0;
    end else begin
      cnt_q   <= tick ? '0 : cnt_q + 1'b1;
      pending <= pend_next(pending, tick, take);
    end
  end
endmodule

// File: rtl/drfsh_rowcnt.sv
module drfsh_rowcnt #(
  parameter int ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide,
  input  logic                step,
  output logic [ROW_BITS-1:0] row
);
  function automatic logic [ROW_BITS-1:0] last_row(input logic w);
    logic [ROW_BITS-1:0] r;
    r = '1;
    if (!w) r[ROW_BITS-1] = 1'b0;
    return r;
  endfunction

  function automatic logic [ROW_BITS-1:0] next_row(input logic [ROW_BITS-1:0] r,
                                                   input logic w);
    return (r >= last_row(w)) ? '0 : r + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= next_row(row, wide);
  end
endmodule

// File: rtl/drfsh_seq.sv
module drfsh_seq
  import drfsh_pkg::*;
#(
  parameter int RAS_LOW   = 4,
  parameter int PRECHARGE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cbr_mode,
  output logic idle,
  output logic cyc_cbr,
  output logic ras_n,
  output logic cas_n,
  output logic addr_en,
  output logic done
);
  localparam int HOLD_MAX = (RAS_LOW > PRECHARGE) ? RAS_LOW : PRECHARGE;
  localparam int HW = $clog2(HOLD_MAX + 1);
  localparam logic [HW-1:0] LOW_LOAD = HW'(RAS_LOW - 1);
  localparam logic [HW-1:0] PRE_LOAD = HW'(PRECHARGE - 1);

  seq_state_e    st_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      hold_q  <= '0;
      cyc_cbr <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          cyc_cbr <= cbr_mode;
          st_q    <= cbr_mode ? ST_CASPRE : ST_SETUP;
        end
        ST_SETUP, ST_CASPRE: begin
          st_q   <= ST_STROBE;
          hold_q <= LOW_LOAD;
        end
        ST_STROBE: begin
          if (hold_q == '0) begin
            st_q   <= cyc_cbr ? ST_CASREL : ST_PRECH;
            hold_q <= PRE_LOAD;
          end else begin
            hold_q <= hold_q - 1'b1;
          end
        end
        ST_CASREL: begin
          st_q   <= ST_PRECH;
          hold_q <= PRE_LOAD;
        end
        ST_PRECH: begin
          if (hold_q == '0) st_q <= ST_DONE;
          else              hold_q <= hold_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (st_q == ST_IDLE);
  assign done    = (st_q == ST_DONE);
  assign ras_n   = !((st_q == ST_STROBE) || (st_q == ST_CASREL));
  assign cas_n   = !((st_q == ST_CASPRE) || ((st_q == ST_STROBE) && cyc_cbr));
  assign addr_en = ((st_q == ST_SETUP) || (st_q == ST_STROBE)) && !cyc_cbr;
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import drfsh_pkg::*;
#(
  parameter int INTERVAL  = 780,
  parameter int RAS_LOW   = 4,
  parameter int PRECHARGE = 3,
  parameter int ROW_BITS  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_cbr,
  input  logic                rows_wide,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                ref_done,
  output logic                ras_n,
  output logic                cas_n,
  output logic                addr_en,
  output logic [ROW_BITS-1:0] ref_addr
);
  logic              tick;
  logic              start;
  logic              owed;
  logic              idle;
  logic              cyc_cbr;
  logic              row_step;
  logic [PEND_W-1:0] pend_cnt;
  logic [ROW_BITS-1:0] row_q;

  assign ref_req  = owed && idle;
  assign start    = ref_req && ref_gnt;
  assign row_step = ref_done && !cyc_cbr;
  assign ref_addr = addr_en ? row_q : '0;

  drfsh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .take(start),
    .tick(tick), .pending(pend_cnt), .owed(owed)
  );

  drfsh_rowcnt #(.ROW_BITS(ROW_BITS)) u_rows (
    .clk(clk), .rst_n(rst_n), .wide(rows_wide), .step(row_step), .row(row_q)
  );

  drfsh_seq #(.RAS_LOW(RAS_LOW), .PRECHARGE(PRECHARGE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cbr_mode(mode_cbr),
    .idle(idle), .cyc_cbr(cyc_cbr), .ras_n(ras_n), .cas_n(cas_n),
    .addr_en(addr_en), .done(ref_done)
  );
endmodule

// File: rtl/drfsh_checker.sv
module drfsh_checker #(
  parameter int ROW_BITS = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ras_n,
  input logic                cas_n,
  input logic                addr_en,
  input logic                ref_req,
  input logic                ref_done,
  input logic                tick,
  input logic                start,
  input logic                cyc_cbr,
  input logic [1:0]          pend_cnt,
  input logic [ROW_BITS-1:0] row
);
  p_setup_before_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && addr_en) |-> ($past(addr_en) && $past(ras_n)));

  p_done_after_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (ras_n && cas_n && $past(ras_n)));

  p_cas_leads_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (addr_en || $past(!cas_n)));

  p_no_addr_with_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !addr_en);

  p_row_moves_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row)) |-> $past(ref_done));

  p_cbr_keeps_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && cyc_cbr) |=> $stable(row));

  p_backlog_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == 2'd2 && tick && !start) |=> (pend_cnt == 2'd2));

  p_req_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (ras_n && cas_n && !ref_done));
endmodule

bind dram_refresh_ctrl drfsh_checker #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .addr_en(addr_en),
  .ref_req(ref_req), .ref_done(ref_done), .tick(tick), .start(start),
  .cyc_cbr(cyc_cbr), .pend_cnt(pend_cnt), .row(row_q)
);

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
  localparam int INTERVAL = 40;
  localparam int RAS_LOW  = 3;
  localparam int PRECH    = 2;
  localparam int RB       = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_cbr = 1'b0, rows_wide = 1'b0, ref_gnt = 1'b0;
  logic ref_req, ref_done, ras_n, cas_n, addr_en;
  logic [RB-1:0] ref_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dram_refresh_ctrl #(.INTERVAL(INTERVAL), .RAS_LOW(RAS_LOW), .PRECHARGE(PRECH),
                      .ROW_BITS(RB)) uut (
    .clk(clk), .rst_n(rst_n), .mode_cbr(mode_cbr), .rows_wide(rows_wide),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_done(ref_done), .ras_n(ras_n),
    .cas_n(cas_n), .addr_en(addr_en), .ref_addr(ref_addr)
  );

  // {cbr, wide, expected row for a row-address cycle}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 1'b0, 9'd0}, {1'b0, 1'b1, 9'd1}, {1'b1, 1'b0, 9'd0}, {1'b0, 1'b0, 9'd2},
    {1'b1, 1'b1, 9'd0}, {1'b1, 1'b0, 9'd0}, {1'b0, 1'b1, 9'd3}, {1'b0, 1'b0, 9'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_gnt = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_refresh(input bit cbr, input bit wide,
                            output int setup_n, output int rlow, output int clow,
                            output int pre_n, output int addr, output bit cas_first,
                            output bit leak, output bit req_dropped);
    bit prev_cas_low;
    bit first;
    setup_n = 0; rlow = 0; clow = 0; pre_n = 0; addr = -1;
    cas_first = 0; leak = 0; req_dropped = 0; prev_cas_low = 0; first = 1;
    mode_cbr = cbr; rows_wide = wide;
    while (!ref_req) @(negedge clk);
    ref_gnt = 1'b1;
    forever begin
      @(negedge clk);
      ref_gnt = 1'b0;
      if (first) req_dropped = !ref_req;
      first = 0;
      if (!ras_n && rlow == 0) cas_first = prev_cas_low;
      if (!ras_n) rlow++;
      if (!cas_n) clow++;
      if (addr_en && ras_n) setup_n++;
      if (ras_n && cas_n && rlow > 0 && !ref_done) pre_n++;
      if (!ras_n && addr_en) addr = int'(ref_addr);
      if (cbr && (addr_en || ref_addr != '0)) leak = 1;
      prev_cas_low = !cas_n;
      if (ref_done) break;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin : main
    int n, s, rl, cl, pr, ad, errs, lows, dones;
    bit cf, lk, rd;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 3);
    check(!ref_req && !ref_done, "R1 req/done", {ref_req, ref_done}, 0);
    check(!addr_en && ref_addr == '0, "R1 addr", int'(ref_addr), 0);
    rst_n = 1'b1;
    // R2: first request after INTERVAL clocks
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_req && n < 5 * INTERVAL);
    check(n == INTERVAL, "R2 first request delay", n, INTERVAL);
    // R9: no strobe before grant
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && ref_req, "R9 idle while ungranted", {ref_req, ras_n, cas_n}, 7);

    // vector table: R3 R4 R5 R7 R9
    foreach (VEC[i]) begin
      do_refresh(VEC[i][10], VEC[i][9], s, rl, cl, pr, ad, cf, lk, rd);
      check(rd, "R9 request falls after grant", 0, 1);
      check(pr == PRECH, "R4 precharge clocks", pr, PRECH);
      if (!VEC[i][10]) begin
        check(s == 1, "R3 setup clocks", s, 1);
        check(rl == RAS_LOW && cl == 0, "R3 ras low clocks", rl, RAS_LOW);
        check(ad == int'(VEC[i][8:0]), "R3/R7 row address", ad, int'(VEC[i][8:0]));
      end else begin
        check(rl == RAS_LOW + 1 && cl == RAS_LOW + 1, "R5 strobe widths", rl * 10 + cl,
              (RAS_LOW + 1) * 11);
        check(cf, "R5 cas before ras", 0, 1);
        check(!lk && s == 0, "R5 no address", s, 0);
      end
    end

    // R6: narrow sweep with wrap
    do_reset();
    errs = 0;
    for (int i = 0; i <= 256; i++) begin
      do_refresh(1'b0, 1'b0, s, rl, cl, pr, ad, cf, lk, rd);
      if (ad != (i % 256) || ad[8]) errs++;
    end
    check(errs == 0, "R6 narrow sweep and wrap", errs, 0);
    // R6: wide sweep with wrap
    do_reset();
    errs = 0;
    for (int i = 0; i <= 512; i++) begin
      do_refresh(1'b0, 1'b1, s, rl, cl, pr, ad, cf, lk, rd);
      if (ad != (i % 512)) errs++;
    end
    check(errs == 0, "R6 wide sweep and wrap", errs, 0);

    // R8: backlog saturates at 2
    do_reset();
    mode_cbr = 1'b0;
    repeat (3 * INTERVAL + 5) @(negedge clk);
    check(ref_req, "R8 request pending", ref_req, 1);
    ref_gnt = 1'b1;
    dones = 0;
    repeat (25) begin @(negedge clk); if (ref_done) dones++; end
    check(dones == 2, "R8 cycles served", dones, 2);
    check(!ref_req, "R8 request cleared", ref_req, 0);
    ref_gnt = 1'b0;

    // R10: grant ignored without request
    do_reset();
    ref_gnt = 1'b1;
    lows = 0; dones = 0;
    repeat (INTERVAL - 5) begin
      @(negedge clk);
      if (!ras_n || !cas_n) lows++;
      if (ref_done) dones++;
    end
    check(lows == 0 && dones == 0, "R10 grant ignored", lows + dones, 0);
    ref_gnt = 1'b0;

    summary();
    $finish;
  end
endmodule